// File: doc/BRIEF.md
# Bidirectional Nibble Turnaround Sequencer

This controller switches a source-synchronous nibble interface between driving and capturing. Software writes a command word on a small register port. The controller then runs a fixed sequence. It pulses a strobe-gate clear for one control cycle, waits one cycle, and asserts a slice reset. The reset is held until two conditions are met: a fast-clock counter has covered the minimum length for the selected serialization width, and at least a set number of control cycles have passed. The controller then releases the reset and waits for the cross-domain handshake to return to rest.

From the first step until the reset is released, both the read-enable and write-enable gating buses are forced to zero. While the reset is active, every slice that is not masked drives its transmit pad to its configured initial level. The controller reports when transmit traffic may resume. It also reports when receive data becomes trustworthy, which happens at the first time the receive FIFO is seen non-empty after release.

The same block also decodes the per-slice transmit gate, the per-slice tristate control and the receive capture gate. These are derived from the (forced) enable buses and the programmed mode.

Top module: `phy_turn_seq`

## Requirements
- R1: A turnaround drives `gate_clr` high for exactly one control cycle, then holds it low for one cycle with `slice_rst` still low, and only then raises `slice_rst`. The two are never high together.
- R2: `rd_en_o` and `wr_en_o` are 0 from the first sequence cycle until `slice_rst` falls. At all other times they equal `rd_en_in` and `wr_en_in`.
- R3: `slice_rst` stays high for at least the fast-clock count selected by mode bits [1:0]: 24 for code 0 (width 2), 40 for code 1 (width 4), and 72 for codes 2 and 3 (width 8). It also stays high for at least one control cycle.
- R4: While `slice_rst` is high, each slice whose bit in the mask register (address 1, 1 = masked) is 0 outputs its `TX_INIT` bit on `tx_d_o`. Masked slices, and every slice outside the reset, pass `tx_d_in` through.
- R5: `tx_ready` is 0 from the first sequence cycle until `slice_rst` falls, and 1 otherwise. `rx_valid` is cleared at the start of a sequence. After release it is set by the first control cycle in which `fifo_empty` is low, and it then stays set.
- R6: `tx_gate_o` (1 = pass) is 1 for slice `UNGATED_SLICE`. It is also 1 for every slice when transmit gating (mode bit 2) is off or the width code is 0. Otherwise it equals the OR of `wr_en_o` bits [3:0] at width 8, or the OR of bits 2 and 0 at width 4.
- R7: A slice whose bit in the tristate-source register (address 2) is 1 gets `t_o` equal to the inverse of the R6 write-enable selection, so a low enable tristates the pad (`t_o` = 1). At width code 0, or when its bit is 0, `t_o` follows `t_in`.
- R8: `rx_gate_o` is 1 when receive gating (mode bit 3) is off. In continuous-strobe mode (mode bit 4) it is the OR of all four `rd_en_o` bits. Otherwise it is the OR of [3:0] at width 8, the OR of bits 2 and 0 at width 4, and 0 at width code 0.
- R9: `busy` is high from the first sequence cycle until the handshake has settled. A command written while `busy` is high starts nothing.
- R10: The register map is as follows. A write to address 0 with bit 0 set requests a turnaround. Address 1 holds the reset mask and address 2 the tristate sources. Address 3 holds the mode: width code in bits [1:0], transmit gating in bit 2, receive gating in bit 3, continuous strobe in bit 4. After reset the mode is width code 2 with everything else 0, and both masks are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ctrl_clk | input | 1 | Control clock |
| ctrl_rst_n | input | 1 | Asynchronous active-low reset, control domain |
| fast_clk | input | 1 | Fast serialization clock |
| fast_rst_n | input | 1 | Asynchronous active-low reset, fast domain |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | NS | Register write data |
| rd_en_in | input | 4 | User read-enable gating bits |
| wr_en_in | input | 4 | User write-enable bits |
| t_in | input | NS | Combinational tristate per slice |
| tx_d_in | input | NS | Transmit level per slice |
| fifo_empty | input | 1 | Receive FIFO empty flag |
| rd_en_o | output | 4 | Read enables after forcing |
| wr_en_o | output | 4 | Write enables after forcing |
| gate_clr | output | 1 | Strobe-gate clear pulse |
| slice_rst | output | 1 | Slice reset |
| busy | output | 1 | Sequence in progress |
| tx_d_o | output | NS | Transmit level to pads |
| t_o | output | NS | Tristate to pads, 1 = high impedance |
| tx_gate_o | output | NS | Transmit gate, 1 = pass |
| rx_gate_o | output | 1 | Capture gate, 1 = open |
| tx_ready | output | 1 | Transmit may proceed |
| rx_valid | output | 1 | Received data trustworthy |

## Verification
The hardest situation to reach is the minimum reset length. It is decided by a counter in the fast domain, and its end returns through two synchronizers. No port exposes the count, and the interval is bounded only loosely by the crossing delays. The stimulus therefore runs one turnaround for each width code. The bench counts fast-clock edges during which `slice_rst` is high and checks that count against a window from the required minimum to a small crossing margin above it. A second command is written into the middle of a running sequence, and the number of `gate_clr` pulses shows whether it was ignored.

// File: rtl/turn_pkg.sv
package turn_pkg;
  typedef enum logic [2:0] {
    TS_IDLE    = 3'd0,
    TS_CLR_ON  = 3'd1,
    TS_CLR_OFF = 3'd2,
    TS_RST     = 3'd3,
    TS_DRAIN   = 3'd4
  } turn_state_t;

  // width codes: 0 -> 2:1, 1 -> 4:1, 2/3 -> 8:1
  localparam logic [1:0] WCODE_2 = 2'd0;
  localparam logic [1:0] WCODE_4 = 2'd1;

  localparam logic [1:0] ADR_GO   = 2'd0;
  localparam logic [1:0] ADR_MASK = 2'd1;
  localparam logic [1:0] ADR_TSRC = 2'd2;
  localparam logic [1:0] ADR_MODE = 2'd3;

  typedef struct packed {
    logic       cont;
    logic       rx_gate;
    logic       tx_gate;
    logic [1:0] width;
  } mode_t;
endpackage

// File: rtl/turn_sync2.sv
module turn_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= 1'b0;
      q    <= 1'b0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/turn_regs.sv
module turn_regs
  import turn_pkg::*;
#(
  parameter int NS = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [1:0]    addr,
  input  logic [NS-1:0] wdata,
  output logic          go,
  output logic [NS-1:0] mask,
  output logic [NS-1:0] tsrc,
  output mode_t         mode
);
  logic mask_en, tsrc_en, mode_en;

  assign go      = we && (addr == ADR_GO) && wdata[0];
  assign mask_en = we && (addr == ADR_MASK);
  assign tsrc_en = we && (addr == ADR_TSRC);
  assign mode_en = we && (addr == ADR_MODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask <= '0;
      tsrc <= '0;
      mode <= '{cont: 1'b0, rx_gate: 1'b0, tx_gate: 1'b0, width: 2'd2};
    end else begin
      if (mask_en) mask <= wdata;
      if (tsrc_en) tsrc <= wdata;
      if (mode_en) mode <= mode_t'(wdata[4:0]);
    end
  end
endmodule

// File: rtl/turn_fsm.sv
module turn_fsm
  import turn_pkg::*;
#(
  parameter int CTRL_MIN = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [1:0] width_in,
  input  logic       done_s,
  input  logic       fifo_empty,
  output logic [1:0] width_q,
  output logic       gate_clr,
  output logic       slice_rst,
  output logic       hold_req,
  output logic       force_low,
  output logic       busy,
  output logic       rx_valid
);
  localparam int CCW = (CTRL_MIN < 2) ? 1 : $clog2(CTRL_MIN + 1);
  localparam logic [CCW-1:0] CYC_MIN = CCW'(CTRL_MIN);

  turn_state_t st, st_n;
  logic [CCW-1:0] cyc, cyc_n;
  logic [1:0] wid_n;
  logic rx_n;

  assign gate_clr  = (st == TS_CLR_ON);
  assign slice_rst = (st == TS_RST);
  assign hold_req  = (st == TS_RST);
  assign force_low = (st == TS_CLR_ON) || (st == TS_CLR_OFF) || (st == TS_RST);
  assign busy      = (st != TS_IDLE);

  always_comb begin
    st_n  = st;
    cyc_n = cyc;
    wid_n = width_q;
    rx_n  = rx_valid;
    case (st)
      TS_IDLE: if (go) begin
        st_n  = TS_CLR_ON;
        wid_n = width_in;
      end
      TS_CLR_ON:  st_n = TS_CLR_OFF;
      TS_CLR_OFF: begin
        st_n  = TS_RST;
        cyc_n = CCW'(1);
      end
      TS_RST: begin
        if (cyc != CYC_MIN) cyc_n = cyc + 1'b1;
        if (done_s && (cyc == CYC_MIN)) st_n = TS_DRAIN;
      end
      TS_DRAIN: if (!done_s) st_n = TS_IDLE;
      default: st_n = TS_IDLE;
    endcase
    if (force_low)        rx_n = 1'b0;
    else if (!fifo_empty) rx_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= TS_IDLE;
      cyc      <= '0;
      width_q  <= 2'd2;
      rx_valid <= 1'b0;
    end else begin
      st       <= st_n;
      cyc      <= cyc_n;
      width_q  <= wid_n;
      rx_valid <= rx_n;
    end
  end
endmodule

// File: rtl/turn_hold.sv
module turn_hold #(
  parameter int HOLD8 = 72,
  parameter int HOLD4 = 40,
  parameter int HOLD2 = 24
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_s,
  input  logic [1:0] width,
  output logic       done
);
  localparam int CW = $clog2(HOLD8 + 1);

  logic [CW-1:0] cnt, cnt_n, tgt;
  logic done_n;

  always_comb begin
    case (width)
      2'd0:    tgt = CW'(HOLD2);
      2'd1:    tgt = CW'(HOLD4);
      default: tgt = CW'(HOLD8);
    endcase
  end

  always_comb begin
    cnt_n  = cnt;
    done_n = done;
    if (!req_s) begin
      cnt_n  = '0;
      done_n = 1'b0;
    end else if (!done) begin
      if (cnt == tgt - 1'b1) done_n = 1'b1;
      else                   cnt_n  = cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      cnt  <= cnt_n;
      done <= done_n;
    end
  end
endmodule

// File: rtl/turn_gate_map.sv
module turn_gate_map
  import turn_pkg::*;
#(
  parameter int NS = 6,
  parameter int UNGATED = 1,
  parameter logic [NS-1:0] TX_INIT = '0
) (
  input  logic          force_low,
  input  logic          slice_rst,
  input  mode_t         mode,
  input  logic [NS-1:0] mask,
  input  logic [NS-1:0] tsrc,
  input  logic [NS-1:0] t_in,
  input  logic [NS-1:0] tx_d_in,
  input  logic [3:0]    rd_en_in,
  input  logic [3:0]    wr_en_in,
  output logic [3:0]    rd_en_o,
  output logic [3:0]    wr_en_o,
  output logic [NS-1:0] t_o,
  output logic [NS-1:0] tx_gate_o,
  output logic [NS-1:0] tx_d_o,
  output logic          rx_gate_o
);
  logic w2, w4, we_sel, rd_sel;

  assign rd_en_o = force_low ? 4'b0 : rd_en_in;
  assign wr_en_o = force_low ? 4'b0 : wr_en_in;
  assign w2 = (mode.width == WCODE_2);
  assign w4 = (mode.width == WCODE_4);

  assign we_sel = w2 ? 1'b0 : w4 ? (wr_en_o[2] | wr_en_o[0]) : (|wr_en_o);
  assign rd_sel = w2 ? 1'b0 : w4 ? (rd_en_o[2] | rd_en_o[0]) : (|rd_en_o);

  assign rx_gate_o = !mode.rx_gate ? 1'b1 : mode.cont ? (|rd_en_o) : rd_sel;

  for (genvar s = 0; s < NS; s++) begin : g_slice
    if (s == UNGATED) begin : g_free
      assign tx_gate_o[s] = 1'b1;
    end else begin : g_gated
      assign tx_gate_o[s] = (mode.tx_gate && !w2) ? we_sel : 1'b1;
    end
    assign t_o[s]    = (tsrc[s] && !w2) ? ~we_sel : t_in[s];
    assign tx_d_o[s] = (slice_rst && !mask[s]) ? TX_INIT[s] : tx_d_in[s];
  end
endmodule

// File: rtl/phy_turn_seq.sv
module phy_turn_seq
  import turn_pkg::*;
#(
  parameter int NS = 6,
  parameter int UNGATED_SLICE = 1,
  parameter logic [NS-1:0] TX_INIT = 6'b010110,
  parameter int HOLD8 = 72,
  parameter int HOLD4 = 40,
  parameter int HOLD2 = 24,
  parameter int CTRL_MIN = 1
) (
  input  logic          ctrl_clk,
  input  logic          ctrl_rst_n,
  input  logic          fast_clk,
  input  logic          fast_rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [NS-1:0] reg_wdata,
  input  logic [3:0]    rd_en_in,
  input  logic [3:0]    wr_en_in,
  input  logic [NS-1:0] t_in,
  input  logic [NS-1:0] tx_d_in,
  input  logic          fifo_empty,
  output logic [3:0]    rd_en_o,
  output logic [3:0]    wr_en_o,
  output logic          gate_clr,
  output logic          slice_rst,
  output logic          busy,
  output logic [NS-1:0] tx_d_o,
  output logic [NS-1:0] t_o,
  output logic [NS-1:0] tx_gate_o,
  output logic          rx_gate_o,
  output logic          tx_ready,
  output logic          rx_valid
);
  logic go, hold_req, req_fast, done_fast, done_ctrl, force_low;
  logic [NS-1:0] rst_mask, tsrc;
  logic [1:0] width_q;
  mode_t mode;

  turn_regs #(.NS(NS)) u_regs (
    .clk(ctrl_clk), .rst_n(ctrl_rst_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .go(go), .mask(rst_mask), .tsrc(tsrc), .mode(mode)
  );

  turn_fsm #(.CTRL_MIN(CTRL_MIN)) u_fsm (
    .clk(ctrl_clk), .rst_n(ctrl_rst_n), .go(go), .width_in(mode.width),
    .done_s(done_ctrl), .fifo_empty(fifo_empty), .width_q(width_q),
    .gate_clr(gate_clr), .slice_rst(slice_rst), .hold_req(hold_req),
    .force_low(force_low), .busy(busy), .rx_valid(rx_valid)
  );

  turn_sync2 u_req_sync (
    .clk(fast_clk), .rst_n(fast_rst_n), .d(hold_req), .q(req_fast)
  );

  // width_q is latched before hold_req rises and is stable while it is high
  turn_hold #(.HOLD8(HOLD8), .HOLD4(HOLD4), .HOLD2(HOLD2)) u_hold (
    .clk(fast_clk), .rst_n(fast_rst_n), .req_s(req_fast), .width(width_q),
    .done(done_fast)
  );

  turn_sync2 u_done_sync (
    .clk(ctrl_clk), .rst_n(ctrl_rst_n), .d(done_fast), .q(done_ctrl)
  );

  turn_gate_map #(.NS(NS), .UNGATED(UNGATED_SLICE), .TX_INIT(TX_INIT)) u_map (
    .force_low(force_low), .slice_rst(slice_rst), .mode(mode),
    .mask(rst_mask), .tsrc(tsrc), .t_in(t_in), .tx_d_in(tx_d_in),
    .rd_en_in(rd_en_in), .wr_en_in(wr_en_in), .rd_en_o(rd_en_o),
    .wr_en_o(wr_en_o), .t_o(t_o), .tx_gate_o(tx_gate_o), .tx_d_o(tx_d_o),
    .rx_gate_o(rx_gate_o)
  );

  assign tx_ready = !force_low;
endmodule

// File: rtl/phy_turn_seq_chk.sv
module phy_turn_seq_chk #(
  parameter int NS = 6,
  parameter int UNGATED = 1,
  parameter logic [NS-1:0] TX_INIT = '0
) (
  input logic          ctrl_clk,
  input logic          ctrl_rst_n,
  input logic          gate_clr,
  input logic          slice_rst,
  input logic          busy,
  input logic          tx_ready,
  input logic [3:0]    rd_en_o,
  input logic [3:0]    wr_en_o,
  input logic [NS-1:0] tx_d_o,
  input logic [NS-1:0] tx_gate_o,
  input logic [NS-1:0] mask
);
  a_r1_clr_precedes_rst: assert property (@(posedge ctrl_clk) disable iff (!ctrl_rst_n)
    $rose(slice_rst) |-> ($past(gate_clr, 2) && !$past(gate_clr)));

  a_r1_never_together: assert property (@(posedge ctrl_clk) disable iff (!ctrl_rst_n)
    !(gate_clr && slice_rst));

  a_r2_enables_low_in_rst: assert property (@(posedge ctrl_clk) disable iff (!ctrl_rst_n)
    slice_rst |-> (rd_en_o == 4'b0 && wr_en_o == 4'b0));

  a_r2_enables_low_before_rst: assert property (@(posedge ctrl_clk) disable iff (!ctrl_rst_n)
    $rose(slice_rst) |-> ($past(rd_en_o) == 4'b0 && $past(wr_en_o) == 4'b0));

  a_r4_init_levels: assert property (@(posedge ctrl_clk) disable iff (!ctrl_rst_n)
    slice_rst |-> (((tx_d_o ^ TX_INIT) & ~mask) == '0));

  a_r5_no_tx_in_rst: assert property (@(posedge ctrl_clk) disable iff (!ctrl_rst_n)
    slice_rst |-> !tx_ready);

  a_r6_free_slice_open: assert property (@(posedge ctrl_clk) disable iff (!ctrl_rst_n)
    tx_gate_o[UNGATED]);

  a_r9_busy_covers: assert property (@(posedge ctrl_clk) disable iff (!ctrl_rst_n)
    (gate_clr || slice_rst) |-> busy);
endmodule

bind phy_turn_seq phy_turn_seq_chk #(.NS(NS), .UNGATED(UNGATED_SLICE), .TX_INIT(TX_INIT)) u_chk (
  .ctrl_clk(ctrl_clk), .ctrl_rst_n(ctrl_rst_n), .gate_clr(gate_clr),
  .slice_rst(slice_rst), .busy(busy), .tx_ready(tx_ready), .rd_en_o(rd_en_o),
  .wr_en_o(wr_en_o), .tx_d_o(tx_d_o), .tx_gate_o(tx_gate_o), .mask(rst_mask)
);

// File: tb/phy_turn_seq_test.sv
module phy_turn_seq_test;
  localparam int CLK_PERIOD  = 10;
  localparam int FAST_PERIOD = 4;
  localparam int NS = 6;
  localparam logic [NS-1:0] INIT = 6'b010110;

  logic ctrl_clk = 1'b0, fast_clk = 1'b0;
  logic ctrl_rst_n, fast_rst_n;
  logic reg_we;
  logic [1:0] reg_addr;
  logic [NS-1:0] reg_wdata;
  logic [3:0] rd_en_in, wr_en_in;
  logic [NS-1:0] t_in, tx_d_in;
  logic fifo_empty;
  logic [3:0] rd_en_o, wr_en_o;
  logic gate_clr, slice_rst, busy, rx_gate_o, tx_ready, rx_valid;
  logic [NS-1:0] tx_d_o, t_o, tx_gate_o;

  int checks = 0, errors = 0;
  int rst_len = 0, clr_cnt = 0;

  always #(CLK_PERIOD/2) ctrl_clk = ~ctrl_clk;
  always #(FAST_PERIOD/2) fast_clk = ~fast_clk;

  always @(negedge fast_clk) if (slice_rst === 1'b1) rst_len++;
  always @(negedge ctrl_clk) if (gate_clr === 1'b1) clr_cnt++;

  phy_turn_seq #(.NS(NS), .TX_INIT(INIT)) uut (
    .ctrl_clk(ctrl_clk), .ctrl_rst_n(ctrl_rst_n), .fast_clk(fast_clk),
    .fast_rst_n(fast_rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .rd_en_in(rd_en_in), .wr_en_in(wr_en_in),
    .t_in(t_in), .tx_d_in(tx_d_in), .fifo_empty(fifo_empty),
    .rd_en_o(rd_en_o), .wr_en_o(wr_en_o), .gate_clr(gate_clr),
    .slice_rst(slice_rst), .busy(busy), .tx_d_o(tx_d_o), .t_o(t_o),
    .tx_gate_o(tx_gate_o), .rx_gate_o(rx_gate_o), .tx_ready(tx_ready),
    .rx_valid(rx_valid)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [NS-1:0] d);
    @(negedge ctrl_clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge ctrl_clk);
    reg_we = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && busy; i++) @(negedge ctrl_clk);
  endtask

  task automatic t_reset();
    rd_en_in = 4'b1010; wr_en_in = 4'b0110;
    #1;
    chk(busy == 1'b0, "R9 reset busy", busy, 0);
    chk(gate_clr == 1'b0 && slice_rst == 1'b0, "R1 reset idle", {gate_clr, slice_rst}, 0);
    chk(rx_valid == 1'b0, "R5 reset rx_valid", rx_valid, 0);
    chk(tx_ready == 1'b1, "R5 reset tx_ready", tx_ready, 1);
    chk(rd_en_o == 4'b1010 && wr_en_o == 4'b0110, "R2 pass-through", {rd_en_o, wr_en_o}, 8'hA6);
    chk(tx_gate_o == 6'h3F, "R10 reset mode no gating", tx_gate_o, 6'h3F);
  endtask

  // one turnaround at a width code with a mask, checking the sequence
  task automatic t_turn(input logic [1:0] wcode, input logic [NS-1:0] msk, input int hold);
    logic [NS-1:0] exp_d;
    wr(2'd3, {4'b0, wcode});
    wr(2'd1, msk);
    rd_en_in = 4'hF; wr_en_in = 4'hF; tx_d_in = 6'b111000;
    exp_d = (INIT & ~msk) | (tx_d_in & msk);
    rst_len = 0; clr_cnt = 0;
    wr(2'd0, 6'd1);
    chk(gate_clr == 1'b1 && slice_rst == 1'b0, "R1 clear first", {gate_clr, slice_rst}, 2);
    chk(busy == 1'b1, "R9 busy on first step", busy, 1);
    chk(rd_en_o == 4'b0 && wr_en_o == 4'b0, "R2 forced at clear", {rd_en_o, wr_en_o}, 0);
    chk(tx_ready == 1'b0, "R5 tx_ready low", tx_ready, 0);
    @(negedge ctrl_clk);
    chk(gate_clr == 1'b0 && slice_rst == 1'b0, "R1 gap cycle", {gate_clr, slice_rst}, 0);
    chk(wr_en_o == 4'b0, "R2 forced in gap", wr_en_o, 0);
    @(negedge ctrl_clk);
    chk(slice_rst == 1'b1, "R1 reset after clear", slice_rst, 1);
    chk(tx_d_o == exp_d, "R4 init levels", tx_d_o, exp_d);
    for (int i = 0; i < 400 && slice_rst; i++) @(negedge ctrl_clk);
    chk(rd_en_o == 4'hF && wr_en_o == 4'hF, "R2 released", {rd_en_o, wr_en_o}, 8'hFF);
    chk(tx_ready == 1'b1, "R5 tx resumes at release", tx_ready, 1);
    chk(tx_d_o == tx_d_in, "R4 pass after release", tx_d_o, tx_d_in);
    wait_idle();
    chk(busy == 1'b0, "R9 busy ends", busy, 0);
    chk(rst_len >= hold && rst_len <= hold + 14, "R3 reset length", rst_len, hold);
    chk(clr_cnt == 1, "R1 one clear pulse", clr_cnt, 1);
  endtask

  task automatic t_ignore();
    wr(2'd3, 6'd1);
    clr_cnt = 0;
    wr(2'd0, 6'd1);
    wr(2'd0, 6'd1);
    for (int i = 0; i < 5; i++) @(negedge ctrl_clk);
    wr(2'd0, 6'd1);
    wait_idle();
    for (int i = 0; i < 10; i++) @(negedge ctrl_clk);
    chk(clr_cnt == 1, "R9 request while busy ignored", clr_cnt, 1);
    chk(busy == 1'b0, "R9 no second sequence", busy, 0);
  endtask

  task automatic t_rx();
    fifo_empty = 1'b1;
    wr(2'd0, 6'd1);
    wait_idle();
    @(negedge ctrl_clk);
    chk(rx_valid == 1'b0, "R5 rx waits for fifo", rx_valid, 0);
    fifo_empty = 1'b0;
    @(negedge ctrl_clk);
    chk(rx_valid == 1'b1, "R5 rx valid on first non-empty", rx_valid, 1);
    fifo_empty = 1'b1;
    @(negedge ctrl_clk);
    chk(rx_valid == 1'b1, "R5 rx valid sticky", rx_valid, 1);
    wr(2'd0, 6'd1);
    wait_idle();
    @(negedge ctrl_clk);
    chk(rx_valid == 1'b0, "R5 rx cleared by turnaround", rx_valid, 0);
  endtask

  task automatic t_gating();
    wr(2'd2, 6'h3F);
    t_in = 6'b100101;
    wr(2'd3, 6'd14); wr_en_in = 4'b0000; #1;
    chk(tx_gate_o == 6'b000010, "R6 w8 gate closed", tx_gate_o, 6'b000010);
    chk(t_o == 6'h3F, "R7 low enable tristates", t_o, 6'h3F);
    wr_en_in = 4'b1000; #1;
    chk(tx_gate_o == 6'h3F, "R6 w8 bit3 opens", tx_gate_o, 6'h3F);
    chk(t_o == 6'h00, "R7 high enable drives", t_o, 0);
    wr(2'd3, 6'd13); wr_en_in = 4'b1000; #1;
    chk(tx_gate_o == 6'b000010, "R6 w4 ignores bit3", tx_gate_o, 6'b000010);
    wr_en_in = 4'b0001; #1;
    chk(tx_gate_o == 6'h3F, "R6 w4 bit0 opens", tx_gate_o, 6'h3F);
    wr(2'd3, 6'd4); wr_en_in = 4'b0000; #1;
    chk(tx_gate_o == 6'h3F, "R6 w2 gating disabled", tx_gate_o, 6'h3F);
    chk(t_o == t_in, "R7 w2 uses t_in", t_o, t_in);
    wr(2'd3, 6'd2); #1;
    chk(tx_gate_o == 6'h3F, "R6 gating off", tx_gate_o, 6'h3F);
    rd_en_in = 4'b0000; #1;
    chk(rx_gate_o == 1'b1, "R8 rx gating off open", rx_gate_o, 1);
    wr(2'd3, 6'd13); rd_en_in = 4'b0010; #1;
    chk(rx_gate_o == 1'b0, "R8 w4 ignores bit1", rx_gate_o, 0);
    rd_en_in = 4'b0100; #1;
    chk(rx_gate_o == 1'b1, "R8 w4 bit2 opens", rx_gate_o, 1);
    wr(2'd3, 6'd25); rd_en_in = 4'b0010; #1;
    chk(rx_gate_o == 1'b1, "R8 continuous OR", rx_gate_o, 1);
    rd_en_in = 4'b0000; #1;
    chk(rx_gate_o == 1'b0, "R8 continuous closed", rx_gate_o, 0);
    wr(2'd3, 6'd8); rd_en_in = 4'hF; #1;
    chk(rx_gate_o == 1'b0, "R8 w2 strobe closed", rx_gate_o, 0);
    wr(2'd3, 6'd24); rd_en_in = 4'b0001; #1;
    chk(rx_gate_o == 1'b1, "R8 w2 continuous", rx_gate_o, 1);
    wr(2'd2, 6'h00); wr(2'd3, 6'd2);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    ctrl_rst_n = 1'b0; fast_rst_n = 1'b0;
    reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    rd_en_in = '0; wr_en_in = '0; t_in = '0; tx_d_in = '0; fifo_empty = 1'b1;
    repeat (3) @(negedge ctrl_clk);
    ctrl_rst_n = 1'b1; fast_rst_n = 1'b1;
    @(negedge ctrl_clk);
    t_reset();
    t_turn(2'd2, 6'b000000, 72);  // R3 width 8
    t_turn(2'd1, 6'b001100, 40);  // R3 width 4, R4 masked slices
    t_turn(2'd0, 6'b100001, 24);  // R3 width 2
    t_turn(2'd3, 6'b000000, 72);  // R3 code 3 as width 8
    t_ignore();
    t_rx();
    t_gating();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule